// File: doc/BRIEF.md
# ADC Result Block-Transfer Controller

This block takes conversion results from an ADC and stores them in memory without the processor's help. Each result that arrives while the controller is running becomes one 16-bit write request on a simple memory write port. The request targets the next address in the current buffer. Software configures three registers: a mode register, an 8-bit transfer count giving the number of results per block, and a start address. A write to the start address arms the controller and resets its progress.

There are two buffering modes. In one-block mode there is a single buffer of `count` words. In two-block mode there are two such buffers back to back, used in alternation. A status bit shows which of the two blocks has just filled. Without the continuous bit, the controller stops after one pass over its buffer or buffers. With the continuous bit, it wraps to the start address and keeps going. The interrupt flag is raised once per completed block, not once per result.

A result that arrives while the previous write still waits for its grant is dropped. A sticky overrun bit records that this happened.

Top module: `adc_xfer_dma`

## Requirements
- R1: After reset the start address reads 0x0200, the mode and count registers read 0, `mem_req` and `irq` are low, and `xfer_active` is low.
- R2: `cfg_sel`=2 writes the start address with bit 0 forced to 0. Every such write re-initialises the controller: the next write goes to the start address, the pending request is dropped and the overrun bit is cleared. The controller becomes active if and only if the count is nonzero.
- R3: Results are ignored before the first start-address write. They are also ignored while the count (`cfg_sel`=1, data bits 7:0) is 0: no request is issued and `xfer_active` stays low.
- R4: For each accepted result, `mem_req` rises one cycle after `res_vld`. It carries `res_data` and the address start+2·n, where n is the transfer number within the pass. It holds address and data until a cycle with `mem_gnt` high.
- R5: In one-block, non-continuous mode, the controller stops after `count` granted writes. It raises `irq` once at that point, and later results are ignored.
- R6: In two-block mode (mode bit 0 set), the second block starts at start+2·count. The flag `irq` rises when each block completes. Without the continuous bit, the controller stops after 2·count writes.
- R7: In two-block mode, mode bit 2 reads 1 after the first block fills and 0 after the second block fills.
- R8: With the continuous bit (mode bit 1) set, the address wraps to the start after the last block, and transfers continue. If the bit is cleared, the controller stops at the end of the current pass.
- R9: A result that arrives while `mem_req` is high is not written. It sets the sticky overrun bit (mode bit 3), which only a start-address write clears.
- R10: `irq_clr` clears `irq` unless a block completes in the same cycle. Mode register bits 7:4 always read 0.
- R11: Writing a count of 0 while the controller is active stops it, and later results are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 count, 2 start address |
| cfg_wdata | input | 16 | Register write data |
| mode_rd | output | 8 | Mode readback {0000, overrun, block-1-filled, continuous, two-block} |
| count_rd | output | 8 | Transfer count readback |
| base_rd | output | 16 | Start address readback |
| res_vld | input | 1 | New ADC result strobe |
| res_data | input | 16 | ADC result value |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write accepted this cycle |
| mem_addr | output | 16 | Memory write byte address |
| mem_data | output | 16 | Memory write data |
| irq_clr | input | 1 | Clear the interrupt flag |
| irq | output | 1 | Block-complete interrupt flag |
| xfer_active | output | 1 | Controller armed and transferring |

## Verification
On every cycle, the assertions check the following:
- A waiting request keeps its address and data stable until granted.
- Request addresses are even.
- A new request appears only after a result arrived while the controller was running.
- The interrupt flag rises only on a granted write.
- An idle controller raises no request.
- The overrun bit is sticky until a restart.

The actual address sequence depends on pass-level behaviour, which only the bench scenarios show. This covers the second-block offset, the wrap in continuous mode, stopping after one or two blocks, the filled-block indicator, and the dropping of overrun results. The bench compares these against its own transfer-level model.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'b00,
        SEL_CNT  = 2'b01,
        SEL_BASE = 2'b10,
        SEL_NONE = 2'b11
    } cfg_sel_e;

    localparam int MODE_DUAL_BIT = 0;
    localparam int MODE_CONT_BIT = 1;

endpackage

// File: rtl/adc_xfer_regs.sv
module adc_xfer_regs
    import adc_xfer_pkg::*;
#(
    parameter int          CNT_W    = 8,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] BASE_RST = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              dual_o,
    output logic              cont_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              start_o
);

    typedef struct packed {
        logic              dual;
        logic              cont;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] base;
    } regs_t;

    regs_t q, d;
    cfg_sel_e sel;

    assign sel = cfg_sel_e'(cfg_sel);

    always_comb begin
        d       = q;
        start_o = 1'b0;
        if (cfg_we) begin
            case (sel)
                SEL_MODE: begin
                    d.dual = cfg_wdata[MODE_DUAL_BIT];
                    d.cont = cfg_wdata[MODE_CONT_BIT];
                end
                SEL_CNT:  d.cnt = cfg_wdata[CNT_W-1:0];
                SEL_BASE: begin
                    d.base  = {cfg_wdata[ADDR_W-1:1], 1'b0};
                    start_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.dual <= 1'b0;
            q.cont <= 1'b0;
            q.cnt  <= '0;
            q.base <= BASE_RST[ADDR_W-1:0];
        end else begin
            q <= d;
        end
    end

    assign dual_o = q.dual;
    assign cont_o = q.cont;
    assign cnt_o  = q.cnt;
    assign base_o = q.base;

endmodule

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dual_i,
    input  logic              cont_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              res_vld_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic              mem_gnt_i,
    input  logic              irq_clr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              irq_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              active_o
);

    localparam int OFF_W = CNT_W + 2;

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  idx;
        logic              blk;
        logic [OFF_W-1:0]  off;
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              irq;
        logic              full;
        logic              ovr;
    } seq_t;

    seq_t q, d;
    logic run, last;

    assign run  = q.active && (cnt_i != '0);
    assign last = (q.idx >= cnt_i - 1'b1);

    always_comb begin
        d = q;
        if (irq_clr_i) d.irq = 1'b0;
        if (start_i) begin
            d.active = (cnt_i != '0);
            d.idx    = '0;
            d.blk    = 1'b0;
            d.off    = '0;
            d.req    = 1'b0;
            d.ovr    = 1'b0;
        end else begin
            d.active = run;
            if (q.req && mem_gnt_i) begin
                d.req = 1'b0;
                if (run) begin
                    if (last) begin
                        d.irq = 1'b1;
                        d.idx = '0;
                        if (dual_i) d.full = !q.blk;
                        if (dual_i && !q.blk) begin
                            d.blk = 1'b1;
                            d.off = q.off + OFF_W'(2);
                        end else if (cont_i) begin
                            d.blk = 1'b0;
                            d.off = '0;
                        end else begin
                            d.active = 1'b0;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.off = q.off + OFF_W'(2);
                    end
                end
            end
            if (res_vld_i && run) begin
                if (q.req) begin
                    d.ovr = 1'b1;
                end else begin
                    d.req  = 1'b1;
                    d.data = res_data_i;
                    d.addr = base_i + ADDR_W'(q.off);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_o  = q.req;
    assign mem_addr_o = q.addr;
    assign mem_data_o = q.data;
    assign irq_o      = q.irq;
    assign full_o     = q.full;
    assign ovr_o      = q.ovr;
    assign active_o   = q.active;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i && !start_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R4
    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !mem_addr_o[0]); // R2
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> $past(res_vld_i) && $past(active_o)); // R3
    AST_IRQ_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mem_req_o) && $past(mem_gnt_i)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o && !mem_req_o && !start_i |=> !mem_req_o); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o && !start_i |=> ovr_o); // R9

endmodule

// File: rtl/adc_xfer_dma.sv
module adc_xfer_dma #(
    parameter int          CNT_W    = 8,
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] BASE_RST = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [7:0]        mode_rd,
    output logic [CNT_W-1:0]  count_rd,
    output logic [ADDR_W-1:0] base_rd,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_data,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              irq_clr,
    output logic              irq,
    output logic              xfer_active
);

    logic dual, cont, start, full, ovr;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] base;

    adc_xfer_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_RST(BASE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dual_o(dual), .cont_o(cont), .cnt_o(cnt), .base_o(base),
        .start_o(start)
    );

    adc_xfer_seq #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .dual_i(dual), .cont_i(cont),
        .cnt_i(cnt), .base_i(base),
        .res_vld_i(res_vld), .res_data_i(res_data),
        .mem_gnt_i(mem_gnt), .irq_clr_i(irq_clr),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
        .irq_o(irq), .full_o(full), .ovr_o(ovr), .active_o(xfer_active)
    );

    assign mode_rd  = {4'b0000, ovr, full, cont, dual};
    assign count_rd = cnt;
    assign base_rd  = base;

endmodule

// File: tb/adc_xfer_dma_test.sv
module adc_xfer_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'b11;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  mode_rd;
    logic [7:0]  count_rd;
    logic [15:0] base_rd;
    logic        res_vld = 1'b0;
    logic [15:0] res_data = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b1;
    logic [15:0] mem_addr;
    logic [15:0] mem_data;
    logic        irq_clr = 1'b0;
    logic        irq;
    logic        xfer_active;

    always #5 clk = ~clk;

    adc_xfer_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mode_rd(mode_rd), .count_rd(count_rd),
        .base_rd(base_rd), .res_vld(res_vld), .res_data(res_data),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_data(mem_data), .irq_clr(irq_clr), .irq(irq),
        .xfer_active(xfer_active)
    );

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1";

    task automatic chk(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // transfer-level reference model
    logic [15:0] m_base;
    logic [7:0]  m_cnt;
    logic        m_dual, m_cont, m_act, m_req, m_irq, m_full, m_ovr;
    logic [15:0] m_addr, m_data;
    int          m_n, m_total;
    logic        m_start, m_run, m_oreq;

    function automatic logic [15:0] addr_of(input logic [15:0] b, input int n);
        return b + 16'(2 * n);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 16'h0200; m_cnt = 0; m_dual = 0; m_cont = 0; m_act = 0;
            m_req = 0; m_irq = 0; m_full = 0; m_ovr = 0; m_n = 0;
            m_addr = 0; m_data = 0;
        end else begin
            m_start = cfg_we && (cfg_sel == 2'b10);
            m_oreq  = m_req;
            if (irq_clr) m_irq = 0;
            if (m_start) begin
                m_act = (m_cnt != 0); m_n = 0; m_req = 0; m_ovr = 0;
            end else begin
                m_run = m_act && (m_cnt != 0);
                m_act = m_run;
                if (m_oreq && mem_gnt) begin
                    m_req = 0;
                    if (m_run) begin
                        m_n++;
                        m_total = int'(m_cnt) * (m_dual ? 2 : 1);
                        if (m_n % int'(m_cnt) == 0) begin
                            m_irq = 1;
                            if (m_dual) m_full = (m_n == int'(m_cnt));
                            if (m_n >= m_total) begin
                                if (m_cont) m_n = 0;
                                else m_act = 0;
                            end
                        end
                    end
                end
                if (res_vld && m_run) begin
                    if (m_oreq) m_ovr = 1;
                    else begin
                        m_req = 1; m_data = res_data; m_addr = addr_of(m_base, m_n);
                    end
                end
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'b00: begin m_dual = cfg_wdata[0]; m_cont = cfg_wdata[1]; end
                    2'b01: m_cnt = cfg_wdata[7:0];
                    2'b10: m_base = {cfg_wdata[15:1], 1'b0};
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, "mem_req", 32'(mem_req), 32'(m_req));
            if (m_req) begin
                chk(tag, "mem_addr", 32'(mem_addr), 32'(m_addr));
                chk(tag, "mem_data", 32'(mem_data), 32'(m_data));
            end
            chk(tag, "irq", 32'(irq), 32'(m_irq));
            chk(tag, "mode_rd", 32'(mode_rd), 32'({4'b0, m_ovr, m_full, m_cont, m_dual}));
            chk(tag, "count_rd", 32'(count_rd), 32'(m_cnt));
            chk(tag, "base_rd", 32'(base_rd), 32'(m_base));
            chk(tag, "xfer_active", 32'(xfer_active), 32'(m_act));
        end
    end

    task automatic cfg(input logic [1:0] s, input logic [15:0] w);
        @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = w;
        @(negedge clk); cfg_we = 0; cfg_sel = 2'b11;
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk); res_vld = 1; res_data = v;
        @(negedge clk); res_vld = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [7:0] c, input logic [1:0] md, input logic [15:0] b);
        cfg(2'b01, {8'h00, c});
        cfg(2'b00, {14'h0, md});
        cfg(2'b10, b);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        tag = "R1";
        chk("R1", "base", 32'(base_rd), 32'h200);
        chk("R1", "mode", 32'(mode_rd), 0);
        chk("R1", "req", 32'(mem_req), 0);
        chk("R1", "irq", 32'(irq), 0);

        // R3: results ignored before any start write
        tag = "R3";
        cfg(2'b01, 16'd3);
        push(16'hAAAA);
        chk("R3", "req before start", 32'(mem_req), 0);
        cfg(2'b01, 16'd0);
        cfg(2'b10, 16'h0300);
        push(16'hBBBB);
        chk("R3", "req with count 0", 32'(mem_req), 0);
        chk("R3", "active with count 0", 32'(xfer_active), 0);

        // R2 / R4 / R5: one block of 3
        tag = "R2";
        arm(8'd3, 2'b00, 16'h1235);
        chk("R2", "base bit0", 32'(base_rd), 32'h1234);
        chk("R2", "active", 32'(xfer_active), 1);
        tag = "R4";
        for (int i = 0; i < 3; i++) begin
            push(16'h100 + 16'(i));
            chk("R4", "req", 32'(mem_req), 1);
            chk("R4", "addr", 32'(mem_addr), 32'(16'h1234 + 16'(2 * i)));
            chk("R4", "data", 32'(mem_data), 32'(16'h100 + 16'(i)));
            if (i < 2) chk("R5", "irq mid-block", 32'(irq), 0);
            idle(1);
        end
        tag = "R5";
        chk("R5", "irq at block end", 32'(irq), 1);
        chk("R5", "stopped", 32'(xfer_active), 0);
        push(16'h7777);
        chk("R5", "ignored after stop", 32'(mem_req), 0);
        tag = "R10";
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R10", "irq cleared", 32'(irq), 0);
        chk("R10", "reserved bits", 32'(mode_rd[7:4]), 0);

        // R6 / R7: two blocks of 2
        tag = "R6";
        arm(8'd2, 2'b01, 16'h0400);
        push(16'h11); idle(1); push(16'h12); idle(1);
        chk("R6", "irq block 1", 32'(irq), 1);
        chk("R7", "block 1 filled", 32'(mode_rd[2]), 1);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        push(16'h13);
        chk("R6", "second block addr", 32'(mem_addr), 32'h0404);
        idle(1);
        push(16'h14);
        chk("R6", "second block addr 2", 32'(mem_addr), 32'h0406);
        idle(1);
        chk("R6", "irq block 2", 32'(irq), 1);
        chk("R7", "block 2 filled", 32'(mode_rd[2]), 0);
        chk("R6", "stopped after two", 32'(xfer_active), 0);

        // R8: continuous wrap, then clear continuous
        tag = "R8";
        arm(8'd2, 2'b10, 16'h0500);
        for (int i = 0; i < 5; i++) begin
            push(16'h50 + 16'(i));
            chk("R8", "wrap addr", 32'(mem_addr), 32'(16'h0500 + 16'(2 * (i % 2))));
            idle(1);
        end
        cfg(2'b00, 16'h0000);
        push(16'h5A); idle(1);
        chk("R8", "stop after cont cleared", 32'(xfer_active), 0);
        push(16'h5B);
        chk("R8", "ignored after cont stop", 32'(mem_req), 0);

        // R9: overrun
        tag = "R9";
        arm(8'd4, 2'b00, 16'h0600);
        mem_gnt = 0;
        push(16'hA1);
        push(16'hA2);
        chk("R9", "overrun set", 32'(mode_rd[3]), 1);
        chk("R9", "first data kept", 32'(mem_data), 32'hA1);
        mem_gnt = 1;
        idle(3);
        chk("R9", "overrun sticky", 32'(mode_rd[3]), 1);
        cfg(2'b10, 16'h0600);
        chk("R9", "overrun cleared by restart", 32'(mode_rd[3]), 0);

        // R11: count 0 stops
        tag = "R11";
        arm(8'd4, 2'b00, 16'h0700);
        push(16'hC1); idle(1);
        cfg(2'b01, 16'd0);
        push(16'hC2);
        chk("R11", "stopped", 32'(xfer_active), 0);
        chk("R11", "no req", 32'(mem_req), 0);

        // random episodes (R4, R6, R8, R9 against model)
        tag = "R4";
        for (int e = 0; e < 300; e++) begin
            arm(8'(1 + $urandom % 5), 2'($urandom % 4), 16'($urandom) & 16'hFFF0);
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                res_vld = ($urandom % 3) == 0;
                res_data = 16'($urandom);
                mem_gnt = ($urandom % 4) != 0;
                irq_clr = ($urandom % 16) == 0;
                if (($urandom % 50) == 0) begin
                    cfg_we = 1; cfg_sel = 2'b00; cfg_wdata = {14'h0, 2'($urandom % 4)};
                end else begin
                    cfg_we = 0; cfg_sel = 2'b11;
                end
            end
            @(negedge clk);
            res_vld = 0; mem_gnt = 1; irq_clr = 0; cfg_we = 0; cfg_sel = 2'b11;
            idle(2);
        end
        finish_run();
    end

endmodule